// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block is a memory-mapped pulse-width modulation peripheral with four independent outputs. Software reaches it over a simple 32-bit word bus with separate read and write strobes. A single shared word turns channels on and off. Each channel also has a private register window that holds a control word, a period count and a duty threshold, plus four holding registers for burst and guard settings. Those four are stored and read back only; they do not affect the output.

Each channel is run by a small two-state machine. `CH_HALT` is the idle state. In it the counter is zero, the output is low, and the working compare registers follow the programmed values. The **start** transition (`CH_HALT` to `CH_COUNT`) is taken on the clock edge after the channel's enable bit becomes 1. In `CH_COUNT` the channel divides the clock by 2^k, where k is the three-bit divide field. It counts from 0 up to the period count and drives its output high while the count is below the threshold. The **wrap** event stays in `CH_COUNT`. It returns the counter to zero and loads the new period, threshold and divide values into the working registers. The **stop** transition (`CH_COUNT` to `CH_HALT`) is taken on the edge after the enable bit becomes 0.

One clock cycle is the base tick. A divide setting of k therefore gives a count resolution of 2^k base ticks.

Top module: `pwmc_top`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: Byte offset 0x000 holds the shared enable word. All 32 bits read back exactly as written. Bit n (n = 0..3) enables channel n when it is 1.
- R3: Channel n's window starts at byte offset 0x10 + n*0x40. Within the window the offsets are: control 0x00, high duration 0x04, low duration 0x08, guard duration 0x0C, wave count 0x28, period 0x2C, threshold 0x30. The control, high, low, guard and wave-count registers keep all 32 bits and read them back unchanged, with no aliasing between channels.
- R4: The period and threshold registers are 13 bits wide (bits 12:0). Their upper bits read as zero.
- R5: The following offsets are unmapped: any offset not listed in R2 or R3, and any offset with address bits 1:0 not equal to zero. Reads of an unmapped offset return zero, and writes to one change no register.
- R6: Enabled with divide 0, period P and threshold T (0 < T <= P), channel n goes through a repeating cycle of P+1 clocks. Its output is high for the first T clocks of each cycle. The first high clock is the second clock edge after the edge that writes the enable bit.
- R7: A threshold of 0 keeps the output constantly low. A threshold greater than the period keeps it constantly high.
- R8: Control bits 2:0 hold k. With k set, each count lasts 2^k clocks, so a period lasts (P+1)*2^k clocks and the high time lasts min(T, P+1)*2^k clocks.
- R9: An output goes low from the edge that clears its enable bit. When the channel is enabled again, it restarts with its prescaler and counter at zero.
- R10: A period or threshold written while a channel is running takes effect only at the next wrap. The pulse in progress keeps its old length.
- R11: Channels run independently. A disabled channel's output stays low while other channels run.
- R12: A read returns its data on `bus_rdata` on the clock edge that samples `bus_rd`. `bus_rdata` is zero in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one base tick |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
Every fault in a channel's counter, prescaler or working registers changes the high/low pattern on `pwm_out`. The bench therefore predicts each output cycle by arithmetic from the programmed period, threshold and divide. A wrong count or wrong divide shows up within one prescaled tick of the fault. A working register that loads at the wrong time changes the high time of the current pulse before it ends. A decode fault shows up on the read one cycle after the access, either as a register that does not hold its value or as one window aliasing another.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    // Per-channel control state
    typedef enum logic [0:0] {
        CH_HALT  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_e;

    // Byte offsets inside a channel window (decoded by software drivers)
    localparam logic [5:0] OFF_CTRL  = 6'h00;
    localparam logic [5:0] OFF_HIGH  = 6'h04;
    localparam logic [5:0] OFF_LOW   = 6'h08;
    localparam logic [5:0] OFF_GUARD = 6'h0C;
    localparam logic [5:0] OFF_WAVE  = 6'h28;
    localparam logic [5:0] OFF_PER   = 6'h2C;
    localparam logic [5:0] OFF_THR   = 6'h30;

    localparam int WIN_FIRST  = 16;
    localparam int WIN_STRIDE = 64;

endpackage

// File: rtl/pwmc_regfile.sv
module pwmc_regfile
    import pwmc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 10,
    parameter int DIV_W  = 3,
    parameter int CNT_W  = 13
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wr,
    input  logic                            bus_rd,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    output logic [NUM_CH-1:0]               en_o,
    output logic [NUM_CH-1:0][DIV_W-1:0]    div_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]    per_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]    thr_o
);

    localparam logic [5:0] WIN_LOW_BITS = 6'(WIN_FIRST);

    logic [31:0] en_q;
    logic [31:0] ctrl_q  [NUM_CH];
    logic [31:0] high_q  [NUM_CH];
    logic [31:0] low_q   [NUM_CH];
    logic [31:0] guard_q [NUM_CH];
    logic [31:0] wave_q  [NUM_CH];
    logic [CNT_W-1:0] per_q [NUM_CH];
    logic [CNT_W-1:0] thr_q [NUM_CH];

    logic              aligned;
    logic              hit_en;
    logic [NUM_CH-1:0] win_hit;
    logic [5:0]        off;
    logic              off_known;
    logic              any_hit;
    logic [31:0]       rd_mux;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign hit_en  = (bus_addr == '0);
    assign off     = bus_addr[5:0] - WIN_LOW_BITS;

    always_comb begin
        unique case (off)
            OFF_CTRL, OFF_HIGH, OFF_LOW, OFF_GUARD,
            OFF_WAVE, OFF_PER, OFF_THR: off_known = 1'b1;
            default:                    off_known = 1'b0;
        endcase
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_win
            localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_FIRST + g * WIN_STRIDE);
            localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_FIRST + (g + 1) * WIN_STRIDE - 1);

            assign win_hit[g] = aligned && off_known &&
                                (bus_addr >= LO) && (bus_addr <= HI);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctrl_q[g]  <= '0;
                    high_q[g]  <= '0;
                    low_q[g]   <= '0;
                    guard_q[g] <= '0;
                    wave_q[g]  <= '0;
                    per_q[g]   <= '0;
                    thr_q[g]   <= '0;
                end else if (bus_wr && win_hit[g]) begin
                    unique case (off)
                        OFF_CTRL:  ctrl_q[g]  <= bus_wdata;
                        OFF_HIGH:  high_q[g]  <= bus_wdata;
                        OFF_LOW:   low_q[g]   <= bus_wdata;
                        OFF_GUARD: guard_q[g] <= bus_wdata;
                        OFF_WAVE:  wave_q[g]  <= bus_wdata;
                        OFF_PER:   per_q[g]   <= bus_wdata[CNT_W-1:0];
                        OFF_THR:   thr_q[g]   <= bus_wdata[CNT_W-1:0];
                        default:   ;
                    endcase
                end
            end

            assign div_o[g] = ctrl_q[g][DIV_W-1:0];
            assign per_o[g] = per_q[g];
            assign thr_o[g] = thr_q[g];
        end
    endgenerate

    assign any_hit = hit_en || (|win_hit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (bus_wr && hit_en) begin
            en_q <= bus_wdata;
        end
    end

    assign en_o = en_q[NUM_CH-1:0];

    always_comb begin
        rd_mux = '0;
        if (hit_en) begin
            rd_mux = en_q;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (win_hit[c]) begin
                unique case (off)
                    OFF_CTRL:  rd_mux = ctrl_q[c];
                    OFF_HIGH:  rd_mux = high_q[c];
                    OFF_LOW:   rd_mux = low_q[c];
                    OFF_GUARD: rd_mux = guard_q[c];
                    OFF_WAVE:  rd_mux = wave_q[c];
                    OFF_PER:   rd_mux = 32'(per_q[c]);
                    OFF_THR:   rd_mux = 32'(thr_q[c]);
                    default:   rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? rd_mux : '0;
        end
    end

    // R5: a read that decodes to nothing returns zero
    p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !any_hit) |=> (bus_rdata == 32'd0));

    // R2: the enable bits follow the last write to the shared word
    p_enable_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_en) |=> (en_o == $past(bus_wdata[NUM_CH-1:0])));

    // R12: no read strobe, no read data
    p_rdata_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 32'd0));

endmodule

// File: rtl/pwmc_prescaler.sv
module pwmc_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             step_o
);

    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // terminal count is 2^k - 1
    assign limit  = ~({PRE_W{1'b1}} << div_i);
    assign step_o = run_i && (pre_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run_i || step_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R8: the divider never runs past its terminal count
    p_pre_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= limit);

    // R9: an idle divider sits at zero
    p_pre_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (pre_q == '0));

endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel
    import pwmc_pkg::*;
#(
    parameter int DIV_W = 3,
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             pwm_o
);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_sh;
    logic [CNT_W-1:0] per_sh;
    logic [CNT_W-1:0] thr_sh;
    logic             run;
    logic             step;
    logic             wrap;

    assign run  = en_i && (state_q == CH_COUNT);
    assign wrap = step && (cnt_q == per_sh);

    pwmc_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div_sh),
        .step_o (step)
    );

    // next-state: start / stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT:  if (en_i)  state_d = CH_COUNT;
            CH_COUNT: if (!en_i) state_d = CH_HALT;
            default:             state_d = CH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // counter and working compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            div_sh <= '0;
            per_sh <= '0;
            thr_sh <= '0;
        end else begin
            unique case (state_q)
                CH_HALT: begin
                    cnt_q  <= '0;
                    div_sh <= div_i;
                    per_sh <= per_i;
                    thr_sh <= thr_i;
                end
                CH_COUNT: begin
                    if (!en_i) begin
                        cnt_q <= '0;
                    end else if (wrap) begin
                        cnt_q  <= '0;
                        div_sh <= div_i;
                        per_sh <= per_i;
                        thr_sh <= thr_i;
                    end else if (step) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // output process
    always_comb begin
        pwm_o = run && (cnt_q < thr_sh);
    end

    // R6: the count stays inside the period
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT) |-> (cnt_q <= per_sh));

    // R9: a disabled channel drives low
    p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !pwm_o);

    // R9: every start begins from a zero count
    p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == CH_COUNT) |-> (cnt_q == '0));

    // R10: working values change only at a wrap while counting
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && !wrap) |=> ($stable(per_sh) && $stable(thr_sh) && $stable(div_sh)));

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 10,
    parameter int DIV_W  = 3,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]            en;
    logic [NUM_CH-1:0][DIV_W-1:0] div;
    logic [NUM_CH-1:0][CNT_W-1:0] per;
    logic [NUM_CH-1:0][CNT_W-1:0] thr;

    pwmc_regfile #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DIV_W  (DIV_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_o      (en),
        .div_o     (div),
        .per_o     (per),
        .thr_o     (thr)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            pwmc_channel #(
                .DIV_W (DIV_W),
                .CNT_W (CNT_W)
            ) u_ch (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (en[g]),
                .div_i (div[g]),
                .per_i (per[g]),
                .thr_i (thr[g]),
                .pwm_o (pwm_out[g])
            );
        end
    endgenerate

endmodule

// File: tb/pwmc_top_test.sv
module pwmc_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    pwmc_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #2 clk = ~clk;

    localparam int O_CTRL = 'h00, O_HIGH = 'h04, O_LOW = 'h08, O_GUARD = 'h0C,
                   O_WAVE = 'h28, O_PER = 'h2C, O_THR = 'h30;

    function automatic int ca(input int ch, input int off);
        return 16 + ch * 64 + off;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // caller stands at a negedge; returns at the next negedge
    task automatic wr_reg(input int a, input logic [31:0] d);
        bus_addr  = 10'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] d);
        bus_addr = 10'(a);
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    function automatic logic [31:0] pat(input int ch, input int off);
        return 32'hC3A5_0000 ^ 32'(ch << 12) ^ 32'(off << 4) ^ 32'h0000_1F0F;
    endfunction

    // R6 / R7 / R8 / R11: one channel alone, every output cycle predicted
    task automatic run_cfg(input int ch, input int k, input int per, input int thr);
        string tag;
        int n;
        logic e;
        wr_reg(ca(ch, O_CTRL), 32'h0000_8008 | 32'(k));
        wr_reg(ca(ch, O_PER), 32'(per));
        wr_reg(ca(ch, O_THR), 32'(thr));
        wr_reg(0, 32'(1 << ch));
        chk("R6 not yet started", 32'(pwm_out), 32'd0);
        if (thr == 0 || thr > per) tag = "R7";
        else if (k > 0)            tag = "R8";
        else                       tag = "R6";
        n = 2 * ((per + 1) << k);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            e = (((j >> k) % (per + 1)) < thr);
            chk(tag, 32'(pwm_out[ch]), 32'(e));
            chk("R11 others low", 32'(pwm_out & ~(4'(1 << ch))), 32'd0);
        end
        wr_reg(0, 32'd0);
        chk("R9 low on disable", 32'(pwm_out), 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic e;
        int pers[4];
        pers = '{0, 1, 3, 6};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 outputs", 32'(pwm_out), 32'd0);
        rd_reg(0, d);
        chk("R1 enable word", d, 32'd0);
        for (int c = 0; c < 4; c++) begin
            foreach (pers[i]) begin end
            rd_reg(ca(c, O_CTRL), d);  chk("R1 ctrl", d, 32'd0);
            rd_reg(ca(c, O_HIGH), d);  chk("R1 high", d, 32'd0);
            rd_reg(ca(c, O_LOW), d);   chk("R1 low", d, 32'd0);
            rd_reg(ca(c, O_GUARD), d); chk("R1 guard", d, 32'd0);
            rd_reg(ca(c, O_WAVE), d);  chk("R1 wave", d, 32'd0);
            rd_reg(ca(c, O_PER), d);   chk("R1 per", d, 32'd0);
            rd_reg(ca(c, O_THR), d);   chk("R1 thr", d, 32'd0);
        end

        // R12: data appears one edge after the strobe and clears after
        chk("R12 idle rdata", bus_rdata, 32'd0);

        // R2: enable word read-back, channel bits clear
        wr_reg(0, 32'hA5C3_5E70);
        rd_reg(0, d);
        chk("R2 readback", d, 32'hA5C3_5E70);
        @(negedge clk);
        chk("R12 rdata cleared", bus_rdata, 32'd0);
        chk("R2 no channel on", 32'(pwm_out), 32'd0);
        wr_reg(0, 32'd0);

        // R3 / R4: full storage and no aliasing
        for (int c = 0; c < 4; c++) begin
            wr_reg(ca(c, O_CTRL),  pat(c, O_CTRL));
            wr_reg(ca(c, O_HIGH),  pat(c, O_HIGH));
            wr_reg(ca(c, O_LOW),   pat(c, O_LOW));
            wr_reg(ca(c, O_GUARD), pat(c, O_GUARD));
            wr_reg(ca(c, O_WAVE),  pat(c, O_WAVE));
            wr_reg(ca(c, O_PER),   pat(c, O_PER));
            wr_reg(ca(c, O_THR),   pat(c, O_THR));
        end
        // R5: writes to unmapped places must not land anywhere
        wr_reg('h004, 32'hFFFF_FFFF);
        wr_reg('h00C, 32'hFFFF_FFFF);
        wr_reg(ca(0, 'h10), 32'hFFFF_FFFF);
        wr_reg(ca(1, 'h3C), 32'hFFFF_FFFF);
        wr_reg(ca(2, 'h02), 32'hFFFF_FFFF);
        wr_reg(ca(4, 0), 32'hFFFF_FFFF);
        wr_reg('h3FC, 32'hFFFF_FFFF);
        for (int c = 0; c < 4; c++) begin
            rd_reg(ca(c, O_CTRL), d);  chk("R3 ctrl", d, pat(c, O_CTRL));
            rd_reg(ca(c, O_HIGH), d);  chk("R3 high", d, pat(c, O_HIGH));
            rd_reg(ca(c, O_LOW), d);   chk("R3 low", d, pat(c, O_LOW));
            rd_reg(ca(c, O_GUARD), d); chk("R3 guard", d, pat(c, O_GUARD));
            rd_reg(ca(c, O_WAVE), d);  chk("R3 wave", d, pat(c, O_WAVE));
            rd_reg(ca(c, O_PER), d);   chk("R4 per", d, pat(c, O_PER) & 32'h1FFF);
            rd_reg(ca(c, O_THR), d);   chk("R4 thr", d, pat(c, O_THR) & 32'h1FFF);
        end
        rd_reg(0, d);               chk("R5 enable untouched", d, 32'd0);
        rd_reg('h004, d);           chk("R5 read 0x004", d, 32'd0);
        rd_reg('h00C, d);           chk("R5 read 0x00C", d, 32'd0);
        rd_reg(ca(0, 'h10), d);     chk("R5 read gap", d, 32'd0);
        rd_reg(ca(1, 'h3C), d);     chk("R5 read tail", d, 32'd0);
        rd_reg(ca(2, 'h02), d);     chk("R5 read misaligned", d, 32'd0);
        rd_reg(ca(4, 0), d);        chk("R5 read past windows", d, 32'd0);
        rd_reg('h3FC, d);           chk("R5 read top", d, 32'd0);
        chk("R5 outputs quiet", 32'(pwm_out), 32'd0);

        // R6 / R7 / R8 / R11: sweep
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 3; k++) begin
                foreach (pers[pi]) begin
                    int p;
                    int thrs[5];
                    p = pers[pi];
                    thrs = '{0, 1, p, p + 1, 7};
                    foreach (thrs[ti]) run_cfg(c, k, p, thrs[ti]);
                end
            end
        end
        // R8: largest divide
        run_cfg(1, 7, 1, 1);

        // R10: reload only at wrap (ch2, k=0, P=4, T=1 -> P=6, T=4)
        wr_reg(ca(2, O_CTRL), 32'h0000_8008);
        wr_reg(ca(2, O_PER), 32'd4);
        wr_reg(ca(2, O_THR), 32'd1);
        wr_reg(0, 32'h4);
        @(negedge clk);
        chk("R10 j0", 32'(pwm_out[2]), 32'd1);
        bus_addr = 10'(ca(2, O_PER)); bus_wdata = 32'd6; bus_wr = 1'b1;
        @(negedge clk);
        chk("R10 j1", 32'(pwm_out[2]), 32'd0);
        bus_addr = 10'(ca(2, O_THR)); bus_wdata = 32'd4;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 j2", 32'(pwm_out[2]), 32'd0);
        for (int j = 3; j < 5 + 14; j++) begin
            @(negedge clk);
            e = (j < 5) ? (j < 1) : (((j - 5) % 7) < 4);
            chk("R10 reload at wrap", 32'(pwm_out[2]), 32'(e));
        end
        wr_reg(0, 32'd0);

        // R9: disable mid-period, restart from zero (ch3, k=1, P=3, T=2)
        wr_reg(ca(3, O_CTRL), 32'h0000_8009);
        wr_reg(ca(3, O_PER), 32'd3);
        wr_reg(ca(3, O_THR), 32'd2);
        wr_reg(0, 32'h8);
        repeat (5) @(negedge clk);
        wr_reg(0, 32'h0);
        chk("R9 low at clear", 32'(pwm_out), 32'd0);
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chk("R9 stays low", 32'(pwm_out), 32'd0);
        end
        wr_reg(0, 32'h8);
        for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            e = (((j >> 1) % 4) < 2);
            chk("R9 restart pattern", 32'(pwm_out[3]), 32'(e));
        end
        wr_reg(0, 32'h0);

        // R11: two channels together (ch0 k=0 P=2 T=1, ch1 k=1 P=4 T=3)
        wr_reg(ca(0, O_CTRL), 32'h0000_8008);
        wr_reg(ca(0, O_PER), 32'd2);
        wr_reg(ca(0, O_THR), 32'd1);
        wr_reg(ca(1, O_CTRL), 32'h0000_8009);
        wr_reg(ca(1, O_PER), 32'd4);
        wr_reg(ca(1, O_THR), 32'd3);
        wr_reg(0, 32'h3);
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            chk("R11 ch0", 32'(pwm_out[0]), 32'((j % 3) < 1));
            chk("R11 ch1", 32'(pwm_out[1]), 32'(((j >> 1) % 5) < 3));
            chk("R11 idle ch", 32'(pwm_out[3:2]), 32'd0);
        end
        wr_reg(0, 32'h0);
        chk("R9 both low", 32'(pwm_out), 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule